// File: doc/BRIEF.md
# Power Converter Startup Supervisor

This block sequences the start-up and fault recovery of a primary-side flyback controller. It watches four comparator flags: drain voltage above the mains-enable level, supply above the start threshold, supply below undervoltage lockout, and supply below a deep reset level. It also watches four fault requests raised by neighbouring blocks: output overvoltage, maximum on-time exceeded, current-sense pin shorted, and over-temperature. From these it drives a converter enable for the gate logic, an enable for the high-voltage start-up current source, and a soft-start request.

There are two fault paths. Undervoltage, an over-long on-time and a shorted sense pin always lead to a safe restart: switching stops, the start-up source recharges the supply, and switching resumes with soft start once the start threshold is crossed again. Overvoltage and over-temperature follow a build-time choice. In auto-restart builds they behave like the other faults. In latched builds the supervisor stops switching for good and lets the supply swing between the start and undervoltage thresholds. Only a drop below the deep reset level clears that latch.

The state is visible on a small status port for observation. All state registers use a synchronous active-high reset.

Top module: `pwr_start_seq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `state_o` is 0, `conv_en` is 0, `src_en` is 1 and `soft_start` is 0.
- R2: `state_o` encodes OFF=0, CHARGE=1, RUN=2, RESTART=3, LATCHED=4. From OFF the block moves to CHARGE at the next edge where `vs_below_reset` is low.
- R3: CHARGE moves to RUN only at an edge where `vs_above_start` is high and `mains_ok` has been high at some edge since OFF was left (the current edge included). Otherwise it stays in CHARGE.
- R4: In RUN, `vs_below_uv` high at an edge moves the block to RESTART at that edge.
- R5: RESTART moves to RUN at an edge where `vs_above_start` is high, provided `vs_above_start` was low at an earlier edge spent in RESTART.
- R6: In RUN, `flt_maxon` or `flt_short` moves the block to RESTART in both build modes.
- R7: In RUN, `flt_ovp` or `flt_otp` moves the block to LATCHED when `LATCH_MODE`=1 and to RESTART when `LATCH_MODE`=0.
- R8: LATCHED is left only through `vs_below_reset`. While latched, `src_en` turns 0 after an edge with `vs_above_start` high and turns 1 again after an edge with `vs_below_uv` high.
- R9: `vs_below_reset` high at an edge sends any state to OFF at that edge. It takes priority over every other input.
- R10: Fault inputs have no effect outside RUN. CHARGE never goes to RESTART or LATCHED.
- R11: `soft_start` is 1 for exactly `SS_LEN` cycles, starting with the edge that enters RUN, and is 0 outside RUN.
- R12: `src_en` stays 1 for the first `TAKEOVER_CYC` cycles in RUN and is 0 after that. It is 1 again from the edge that enters RESTART.
- R13: `conv_en` is 1 exactly when `state_o` is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mains_ok | input | 1 | Drain voltage above mains-enable level |
| vs_above_start | input | 1 | Supply above start threshold |
| vs_below_uv | input | 1 | Supply below undervoltage lockout level |
| vs_below_reset | input | 1 | Supply below deep reset level |
| flt_ovp | input | 1 | Output overvoltage trip request |
| flt_maxon | input | 1 | Maximum on-time exceeded |
| flt_short | input | 1 | Current-sense pin shorted |
| flt_otp | input | 1 | Over-temperature trip request |
| conv_en | output | 1 | Converter switching enable |
| src_en | output | 1 | Start-up current source enable |
| soft_start | output | 1 | Soft-start request |
| state_o | output | 3 | Current state code |

## Verification
A wrong internal state shows up at the ports one edge after the input that caused it. `state_o` and `conv_en` move together, so a missed or spurious transition is visible in the next sample. A lost mains-seen memory or restart arming flag shows up as RUN being entered one edge too early, or never. A corrupted latch-hysteresis flag shows up as `src_en` holding the wrong level on the edge after a threshold flag. Errors in the soft-start and takeover counters appear at the exact cycle where the `soft_start` or `src_en` window should close.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_CHG  = 3'd1,
    ST_RUN  = 3'd2,
    ST_RST  = 3'd3,
    ST_LAT  = 3'd4
  } sup_state_e;
endpackage

// File: rtl/pss_fault_gate.sv
module pss_fault_gate #(
  parameter bit LATCH_MODE = 1'b1
) (
  input  logic in_run,
  input  logic flt_ovp,
  input  logic flt_maxon,
  input  logic flt_short,
  input  logic flt_otp,
  output logic trip_restart,
  output logic trip_latch
);
  logic hard_flt;
  logic soft_flt;

  assign hard_flt = flt_ovp | flt_otp;
  assign soft_flt = flt_maxon | flt_short;

  generate
    if (LATCH_MODE) begin : g_latched
      assign trip_latch   = in_run & hard_flt;
      assign trip_restart = in_run & soft_flt;
    end else begin : g_auto
      assign trip_latch   = 1'b0;
      assign trip_restart = in_run & (hard_flt | soft_flt);
    end
  endgenerate
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mains_ok,
  input  logic       vs_above_start,
  input  logic       vs_below_uv,
  input  logic       vs_below_reset,
  input  logic       trip_restart,
  input  logic       trip_latch,
  output sup_state_e state_q,
  output sup_state_e state_d,
  output logic       enter_run,
  output logic       hold_d
);
  logic mains_seen_q;
  logic armed_q;
  logic hold_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF: state_d = ST_CHG;
      ST_CHG: if ((mains_seen_q | mains_ok) & vs_above_start) state_d = ST_RUN;
      ST_RUN: begin
        if (trip_latch)                      state_d = ST_LAT;
        else if (trip_restart | vs_below_uv) state_d = ST_RST;
      end
      ST_RST: if (armed_q & vs_above_start) state_d = ST_RUN;
      ST_LAT: state_d = ST_LAT;
      default: state_d = ST_OFF;
    endcase
    if (vs_below_reset) state_d = ST_OFF;
  end

  always_comb begin
    hold_d = hold_q;
    if (state_q != ST_LAT)              hold_d = 1'b0;
    else if (!hold_q && vs_above_start) hold_d = 1'b1;
    else if (hold_q && vs_below_uv)     hold_d = 1'b0;
  end

  assign enter_run = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_OFF;
      mains_seen_q <= 1'b0;
      armed_q      <= 1'b0;
      hold_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      if (state_d == ST_OFF)  mains_seen_q <= 1'b0;
      else if (mains_ok)      mains_seen_q <= 1'b1;
      if (state_q != ST_RST)  armed_q <= 1'b0;
      else if (!vs_above_start) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pss_out_reg.sv
module pss_out_reg
  import pss_pkg::*;
#(
  parameter int SS_LEN       = 4,
  parameter int TAKEOVER_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  sup_state_e state_d,
  input  logic       enter_run,
  input  logic       hold_d,
  output logic       conv_en,
  output logic       src_en,
  output logic       soft_start,
  output logic [2:0] state_o
);
  localparam int SSW = $clog2(SS_LEN + 1);
  localparam int TKW = $clog2(TAKEOVER_CYC + 2);
  localparam logic [SSW-1:0] SS_LOAD = SSW'(SS_LEN - 1);
  localparam logic [TKW-1:0] TK_LIM  = TKW'(TAKEOVER_CYC);

  logic [SSW-1:0] ss_cnt;
  logic [TKW-1:0] tk_cnt;
  logic [TKW-1:0] tk_inc;

  assign tk_inc = tk_cnt + TKW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o    <= ST_OFF;
      conv_en    <= 1'b0;
      src_en     <= 1'b1;
      soft_start <= 1'b0;
      ss_cnt     <= '0;
      tk_cnt     <= '0;
    end else begin
      state_o <= state_d;
      conv_en <= (state_d == ST_RUN);
      if (enter_run) begin
        soft_start <= 1'b1;
        ss_cnt     <= SS_LOAD;
        tk_cnt     <= '0;
        src_en     <= (TAKEOVER_CYC > 0);
      end else if (state_d == ST_RUN) begin
        soft_start <= (ss_cnt != '0);
        if (ss_cnt != '0) ss_cnt <= ss_cnt - SSW'(1);
        if (tk_cnt < TK_LIM) tk_cnt <= tk_inc;
        src_en <= (tk_inc < TK_LIM);
      end else begin
        soft_start <= 1'b0;
        src_en     <= !((state_d == ST_LAT) && hold_d);
      end
    end
  end
endmodule

// File: rtl/pwr_start_seq.sv
module pwr_start_seq
  import pss_pkg::*;
#(
  parameter bit LATCH_MODE   = 1'b1,
  parameter int SS_LEN       = 4,
  parameter int TAKEOVER_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mains_ok,
  input  logic       vs_above_start,
  input  logic       vs_below_uv,
  input  logic       vs_below_reset,
  input  logic       flt_ovp,
  input  logic       flt_maxon,
  input  logic       flt_short,
  input  logic       flt_otp,
  output logic       conv_en,
  output logic       src_en,
  output logic       soft_start,
  output logic [2:0] state_o
);
  sup_state_e state_q;
  sup_state_e state_d;
  logic       enter_run;
  logic       hold_d;
  logic       trip_restart;
  logic       trip_latch;

  pss_fault_gate #(.LATCH_MODE(LATCH_MODE)) u_gate (
    .in_run       (state_q == ST_RUN),
    .flt_ovp      (flt_ovp),
    .flt_maxon    (flt_maxon),
    .flt_short    (flt_short),
    .flt_otp      (flt_otp),
    .trip_restart (trip_restart),
    .trip_latch   (trip_latch)
  );

  pss_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .mains_ok       (mains_ok),
    .vs_above_start (vs_above_start),
    .vs_below_uv    (vs_below_uv),
    .vs_below_reset (vs_below_reset),
    .trip_restart   (trip_restart),
    .trip_latch     (trip_latch),
    .state_q        (state_q),
    .state_d        (state_d),
    .enter_run      (enter_run),
    .hold_d         (hold_d)
  );

  pss_out_reg #(.SS_LEN(SS_LEN), .TAKEOVER_CYC(TAKEOVER_CYC)) u_out (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .enter_run  (enter_run),
    .hold_d     (hold_d),
    .conv_en    (conv_en),
    .src_en     (src_en),
    .soft_start (soft_start),
    .state_o    (state_o)
  );
endmodule

// File: rtl/pss_chk.sv
module pss_chk (
  input logic       clk,
  input logic       rst,
  input logic       vs_above_start,
  input logic       vs_below_reset,
  input logic       conv_en,
  input logic       soft_start,
  input logic [2:0] state_o
);
  AST_CONV_IFF_RUN: assert property (@(posedge clk) disable iff (rst)
    conv_en == (state_o == 3'd2)); // R13

  AST_RESET_LEVEL_OFF: assert property (@(posedge clk) disable iff (rst)
    vs_below_reset |=> (state_o == 3'd0)); // R9

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && !vs_below_reset) |=> (state_o == 3'd4)); // R8

  AST_CHARGE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && !vs_below_reset) |=> (state_o == 3'd1 || state_o == 3'd2)); // R10

  AST_CHARGE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && !vs_above_start) |=> (state_o != 3'd2)); // R3

  AST_SS_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    soft_start |-> conv_en); // R11

  AST_SS_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_en) |-> soft_start); // R11
endmodule

bind pwr_start_seq pss_chk u_chk (.*);

// File: tb/sim_pwr_start_seq.sv
module sim_pwr_start_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mains_ok = 0, vs_above_start = 0, vs_below_uv = 0, vs_below_reset = 0;
  logic flt_ovp = 0, flt_maxon = 0, flt_short = 0, flt_otp = 0;
  logic conv0, src0, ss0, conv1, src1, ss1;
  logic [2:0] st0, st1;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_start_seq #(.LATCH_MODE(1'b1), .SS_LEN(4), .TAKEOVER_CYC(8)) u0 (
    .clk(clk), .rst(rst), .mains_ok(mains_ok), .vs_above_start(vs_above_start),
    .vs_below_uv(vs_below_uv), .vs_below_reset(vs_below_reset), .flt_ovp(flt_ovp),
    .flt_maxon(flt_maxon), .flt_short(flt_short), .flt_otp(flt_otp),
    .conv_en(conv0), .src_en(src0), .soft_start(ss0), .state_o(st0));

  pwr_start_seq #(.LATCH_MODE(1'b0), .SS_LEN(4), .TAKEOVER_CYC(8)) u1 (
    .clk(clk), .rst(rst), .mains_ok(mains_ok), .vs_above_start(vs_above_start),
    .vs_below_uv(vs_below_uv), .vs_below_reset(vs_below_reset), .flt_ovp(flt_ovp),
    .flt_maxon(flt_maxon), .flt_short(flt_short), .flt_otp(flt_otp),
    .conv_en(conv1), .src_en(src1), .soft_start(ss1), .state_o(st1));

  // inputs {mains,start,uv,rlv, ovp,maxon,short,otp} | exp u0 state | exp u1 state | exp u0 conv
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    15'b0010_0000_001_001_0,  // R2 OFF->CHARGE
    15'b0100_0000_001_001_0,  // R3 start without mains
    15'b1000_0000_001_001_0,  // R3 mains noted
    15'b0100_0000_010_010_1,  // R3 start, mains remembered
    15'b0100_0000_010_010_1,
    15'b0010_0000_011_011_0,  // R4 undervoltage
    15'b0010_0000_011_011_0,  // R5 arming
    15'b0100_0000_010_010_1,  // R5 restart
    15'b0100_0100_011_011_0,  // R6 max on-time
    15'b0100_0100_011_011_0,  // R5 R10 not armed, fault ignored
    15'b0000_0000_011_011_0,
    15'b0100_0000_010_010_1,
    15'b0100_0010_011_011_0,  // R6 shorted sense
    15'b0000_0000_011_011_0,
    15'b0100_0000_010_010_1,
    15'b0100_0001_100_011_0,  // R7 over-temperature
    15'b0010_0000_100_011_0,  // R8
    15'b0100_0000_100_010_0,  // R8 latched stays, auto restarts
    15'b0100_1000_100_011_0,  // R7 overvoltage in auto mode
    15'b0011_0000_000_000_0,  // R9 reset level
    15'b0010_0000_001_001_0   // R3 mains memory cleared
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [7:0] v);
    {mains_ok, vs_above_start, vs_below_uv, vs_below_reset,
     flt_ovp, flt_maxon, flt_short, flt_otp} = v;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    {mains_ok, vs_above_start, vs_below_uv, vs_below_reset,
     flt_ovp, flt_maxon, flt_short, flt_otp} = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 state", st0, 0);
    chk("R1 conv_en", conv0, 0);
    chk("R1 src_en", src0, 1);
    chk("R1 soft_start", ss0, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drv(VEC[i][14:7]);
      chk($sformatf("R2 step%0d latched-build state", i + 1), st0, VEC[i][6:4]);
      chk($sformatf("R7 step%0d auto-build state", i + 1), st1, VEC[i][3:1]);
      chk($sformatf("R13 step%0d conv_en", i + 1), conv0, VEC[i][0]);
    end

    // R11 R12 soft-start window and source takeover
    do_reset();
    drv(8'b0010_0000);
    drv(8'b1100_0000);
    chk("R11 entry soft_start", ss0, 1);
    chk("R12 entry src_en", src0, 1);
    for (int j = 1; j <= 9; j++) begin
      drv(8'b0100_0000);
      chk($sformatf("R11 soft_start cycle %0d", j), ss0, (j < 4) ? 1 : 0);
      chk($sformatf("R12 src_en cycle %0d", j), src0, (j < 8) ? 1 : 0);
    end
    drv(8'b0010_0000);
    chk("R12 src_en back on in restart", src0, 1);
    chk("R11 soft_start off in restart", ss0, 0);
    chk("R4 restart on undervoltage", st0, 3);

    // R10 faults ignored in CHARGE
    do_reset();
    drv(8'b0010_0000);
    drv(8'b0000_1111);
    chk("R10 latched-build state", st0, 1);
    chk("R10 auto-build state", st1, 1);
    chk("R10 conv_en", conv0, 0);

    // R8 hysteresis of the source while latched
    drv(8'b1100_0000);
    chk("R3 run", st0, 2);
    drv(8'b0100_1000);
    chk("R7 latched on overvoltage", st0, 4);
    chk("R8 src_en on at latch entry", src0, 1);
    drv(8'b0100_0000);
    chk("R8 src_en off above start", src0, 0);
    drv(8'b0000_0000);
    chk("R8 src_en held off", src0, 0);
    drv(8'b0010_0000);
    chk("R8 src_en on below uv", src0, 1);
    drv(8'b1100_1111);
    chk("R8 latch holds", st0, 4);
    chk("R8 latch conv_en", conv0, 0);
    drv(8'b0001_0000);
    chk("R9 latch cleared", st0, 0);

    // R1 synchronous reset from RUN
    drv(8'b0000_0000);
    drv(8'b1100_0000);
    chk("R3 run again", st0, 2);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset from run state", st0, 0);
    chk("R1 reset from run conv_en", conv0, 0);
    rst = 1'b0;

    done = 1;
    finish_run();
  end
endmodule